// File: doc/BRIEF.md
# SPI Flash Command Engine with Shared Ring Buffer

This block is a single-command SPI master for serial flash devices, driven through a small byte-wide register port. Software loads a command byte, a packed pair of byte counts (how many payload bytes to send, how many response bytes to collect) and the payload itself. It then sets a start bit and polls that same bit until it drops. The engine lowers chip select, shifts out the command byte, and then shifts one further byte for each payload and response byte requested. It uses SPI mode 0 with the most significant bit first.

Send and receive data share one eight-entry ring buffer, and a three-bit pointer is visible to software. Each byte shifted after the command is taken from the entry at the pointer. The byte captured from the device during that same byte time is written back into that entry, and then the pointer advances. The buffer is never cleared. After a transaction, software resets the pointer, skips the entries it wrote, and reads the response bytes.

The control sequencer has three states. In `S_IDLE`, chip select is high and the engine waits for a start request (transition `IDLE->SHIFT` on start). In `S_SHIFT`, chip select is low and bytes are clocked out and in; after the final bit of the final byte the sequencer moves to the gap state (transition `SHIFT->GAP`). In `S_GAP`, chip select is high again and the engine waits one full SCK period before returning to idle and dropping busy (transition `GAP->IDLE`).

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy reads 0, chip select is high, SCK is low, the pointer is 0, offsets 0 and 1 read 0x00, and offset 0xD reads 0x10 (clock select field = 01).
- R2: Offset 1 holds the counts: bits 3:0 are the payload (send) count and bits 7:4 are the response (receive) count. It reads back exactly the value written.
- R3: A write to offset 0xC stores the byte at the pointer entry and advances the pointer. A read of 0xC returns the byte at the pointer entry and advances the pointer. The pointer is 3 bits wide and wraps modulo 8. Bits 2:0 of offset 0xD read the pointer.
- R4: Writing a byte with bit 4 set to offset 2 sets the pointer to 0.
- R5: Writing a byte with bit 0 set to offset 2 starts a transaction. Bit 0 of offset 2 then reads 1 until the transaction ends, and reads 0 afterwards.
- R6: On the wire, the command byte (offset 0) goes first, in SPI mode 0 with MSB first. It is followed by exactly payload count + response count further bytes. When both counts are 0, only the command byte is sent.
- R7: A transaction starts at pointer 0. Each byte after the command is sent from the entry at the pointer; the byte received during it replaces that entry, and the pointer advances. At the end, the pointer equals (payload count + response count) mod 8. Entries are never cleared, so in transactions longer than 8 bytes the later bytes send data received earlier.
- R8: Bits 5:4 of offset 0xD set the SCK period in system clocks: 01 gives 2, 10 gives 3, 11 gives 4, and 00 gives 2. The setting is sampled when a transaction starts.
- R9: While busy, the following have no effect: writes to offsets 0 and 1, writes to the data port, the pointer-reset bit, and reads of the data port.
- R10: Chip select falls at least half an SCK period before the first rising SCK edge and stays low through the final bit. It then stays high for at least one full SCK period before busy clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (66 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe; advances the pointer when reading the data port |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| spi_sck | output | 1 | SPI serial clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
A pointer that is off by one, or that fails to reset at start, shows up in the first response byte a transaction captures. It also shows up in the pointer field read right after busy drops. Both are visible within one command. A sequencer that leaves the shift state one byte early or late changes the byte count seen by the device model and the final pointer value. A bad clock divider shows up as an SCK period or lead time that is wrong from the first bit. Because the ring is never cleared, any stray write while busy corrupts the entries sent by the next long transaction. The bench therefore checks all eight entries after every command.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_GAP   = 2'd2
    } eng_state_t;

    localparam int          ADDR_W     = 4;
    localparam logic [3:0]  OFS_OPCODE = 4'h0;
    localparam logic [3:0]  OFS_COUNT  = 4'h1;
    localparam logic [3:0]  OFS_CTRL   = 4'h2;
    localparam logic [3:0]  OFS_DATA   = 4'hC;
    localparam logic [3:0]  OFS_CFG    = 4'hD;
    localparam int          CTRL_GO    = 0;
    localparam int          CTRL_CLR   = 4;
    localparam int          CFG_RATE_LO = 4;
    localparam logic [1:0]  RATE_RESET = 2'b01;

    // SCK period in system clocks for a clock-select code
    function automatic int unsigned sck_period(input logic [1:0] sel);
        case (sel)
            2'b10:   return 3;
            2'b11:   return 4;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
    import spi_cmd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       rise_tk,
    output logic       fall_tk
);

    logic [CNT_W-1:0] cnt_q, per_q, low_q;

    // Period and low-phase length are latched while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= CNT_W'(2);
            low_q <= CNT_W'(1);
        end else if (!en) begin
            cnt_q <= '0;
            per_q <= CNT_W'(sck_period(rate_sel));
            low_q <= CNT_W'((sck_period(rate_sel) + 1) / 2);
        end else if (cnt_q == per_q - CNT_W'(1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign rise_tk = en && (cnt_q == low_q - CNT_W'(1));
    assign fall_tk = en && (cnt_q == per_q - CNT_W'(1));

    p_tick_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_tk, fall_tk}));

    p_fall_follows_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tk |=> !rise_tk);

endmodule

// File: rtl/spi_ring_fifo.sv
module spi_ring_fifo #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              eng_wr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] cur_data,
    output logic [DATA_W-1:0] nxt_data,
    output logic [$clog2(DEPTH)-1:0] ptr
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic              any_wr;

    assign any_wr = host_wr || eng_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (clr) begin
            ptr_q <= '0;
        end else if (any_wr || host_rd) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    // Entries are only ever overwritten, never cleared
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (any_wr && !clr) begin
            mem_q[ptr_q] <= host_wr ? host_wdata : eng_wdata;
        end
    end

    assign cur_data = mem_q[ptr_q];
    assign nxt_data = mem_q[ptr_q + PTR_W'(1)];
    assign ptr      = ptr_q;

    p_one_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && eng_wr));

    p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr || host_rd) && !clr && ptr_q == PTR_W'(DEPTH - 1) |=> ptr_q == '0);

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] opcode,
    input  logic [IDX_W-1:0]  total,
    input  logic              rise_tk,
    input  logic              fall_tk,
    input  logic              miso,
    input  logic [DATA_W-1:0] fifo_cur,
    input  logic [DATA_W-1:0] fifo_nxt,
    output logic              busy,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi,
    output logic              eng_wr,
    output logic [DATA_W-1:0] eng_wdata,
    output logic              div_en
);

    localparam int BIT_W = $clog2(DATA_W);

    eng_state_t        state_q, state_d;
    logic [DATA_W-1:0] tx_q, rx_q;
    logic [BIT_W-1:0]  bit_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sck_q;
    logic              byte_end, last_byte;

    assign byte_end  = fall_tk && (bit_q == BIT_W'(DATA_W - 1));
    assign last_byte = (idx_q == total);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go)                     state_d = S_SHIFT;
            S_SHIFT: if (byte_end && last_byte)  state_d = S_GAP;
            S_GAP:   if (fall_tk)                state_d = S_IDLE;
            default:                             state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            rx_q  <= '0;
            bit_q <= '0;
            idx_q <= '0;
            sck_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    sck_q <= 1'b0;
                    if (go) begin
                        tx_q  <= opcode;
                        bit_q <= '0;
                        idx_q <= '0;
                    end
                end
                S_SHIFT: begin
                    if (rise_tk) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[DATA_W-2:0], miso};
                    end
                    if (fall_tk) begin
                        sck_q <= 1'b0;
                        bit_q <= bit_q + BIT_W'(1);
                        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
                        if (byte_end) begin
                            idx_q <= idx_q + IDX_W'(1);
                            if (!last_byte)
                                tx_q <= (idx_q == '0) ? fifo_cur : fifo_nxt;
                        end
                    end
                end
                default: sck_q <= 1'b0;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        cs_n      = (state_q != S_SHIFT);
        sck       = sck_q;
        mosi      = tx_q[DATA_W-1];
        eng_wr    = (state_q == S_SHIFT) && byte_end && (idx_q != '0);
        eng_wdata = rx_q;
        div_en    = busy;
    end

    p_sck_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_mosi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sck && $past(sck) |-> $stable(mosi));

    p_gap_before_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> busy);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam int IDX_W = CNT_W + 1;
    localparam int DIV_W = 3;

    logic [DATA_W-1:0]  opcode_q;
    logic [2*CNT_W-1:0] count_q;
    logic [1:0]         rate_q;
    logic [IDX_W-1:0]   total;
    logic               busy, go, clr, host_wr, host_rd;
    logic               rise_tk, fall_tk, div_en, eng_wr;
    logic [DATA_W-1:0]  eng_wdata, fifo_cur, fifo_nxt;
    logic [PTR_W-1:0]   ptr;
    logic               wr_ctrl;

    assign total   = IDX_W'(count_q[CNT_W-1:0]) + IDX_W'(count_q[2*CNT_W-1:CNT_W]);
    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL) && !busy;
    assign go      = wr_ctrl && reg_wdata[CTRL_GO];
    assign clr     = wr_ctrl && (reg_wdata[CTRL_CLR] || reg_wdata[CTRL_GO]);
    assign host_wr = reg_wr && (reg_addr == OFS_DATA) && !busy;
    assign host_rd = reg_rd && (reg_addr == OFS_DATA) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q <= '0;
            count_q  <= '0;
            rate_q   <= RATE_RESET;
        end else if (reg_wr) begin
            if (reg_addr == OFS_OPCODE && !busy) opcode_q <= reg_wdata;
            if (reg_addr == OFS_COUNT  && !busy) count_q  <= reg_wdata[2*CNT_W-1:0];
            if (reg_addr == OFS_CFG)             rate_q   <= reg_wdata[CFG_RATE_LO +: 2];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_OPCODE: reg_rdata = opcode_q;
            OFS_COUNT:  reg_rdata = DATA_W'(count_q);
            OFS_CTRL:   reg_rdata[CTRL_GO] = busy;
            OFS_DATA:   reg_rdata = fifo_cur;
            OFS_CFG: begin
                reg_rdata[CFG_RATE_LO +: 2] = rate_q;
                reg_rdata[PTR_W-1:0]        = ptr;
            end
            default:    reg_rdata = '0;
        endcase
    end

    spi_clk_div #(.CNT_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (div_en),
        .rate_sel (rate_q),
        .rise_tk  (rise_tk),
        .fall_tk  (fall_tk)
    );

    spi_ring_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (reg_wdata),
        .eng_wr     (eng_wr),
        .eng_wdata  (eng_wdata),
        .cur_data   (fifo_cur),
        .nxt_data   (fifo_nxt),
        .ptr        (ptr)
    );

    spi_shift_fsm #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .opcode    (opcode_q),
        .total     (total),
        .rise_tk   (rise_tk),
        .fall_tk   (fall_tk),
        .miso      (spi_miso),
        .fifo_cur  (fifo_cur),
        .fifo_nxt  (fifo_nxt),
        .busy      (busy),
        .cs_n      (spi_cs_n),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .eng_wr    (eng_wr),
        .eng_wdata (eng_wdata),
        .div_en    (div_en)
    );

    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    p_end_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ptr == total[PTR_W-1:0]);

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(opcode_q) && $stable(count_q));

endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;
    import spi_cmd_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_cs_n, spi_mosi;
    logic       spi_miso = 1'b0;

    always #2 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // {opcode, send count, receive count, 6'b0, clock select}
    localparam logic [23:0] VEC [6] = '{
        {8'h9F, 4'd0, 4'd3, 6'd0, 2'b01},
        {8'h05, 4'd0, 4'd0, 6'd0, 2'b10},
        {8'h03, 4'd3, 4'd5, 6'd0, 2'b11},
        {8'h0B, 4'd4, 4'd8, 6'd0, 2'b00},
        {8'h02, 4'd8, 4'd8, 6'd0, 2'b01},
        {8'hAB, 4'd1, 4'd2, 6'd0, 2'b10}
    };

    int errors = 0, checks = 0, cyc = 0;
    logic [7:0] m [8];

    // device model state
    logic [7:0] s_tx, s_rx;
    int         s_bits = 0, cap_n = 0;
    logic [7:0] cap [32];
    time        t_cs_fall = 0, t_cs_rise = 0, t_prev = 0;
    time        lead_ns = 0, per_ns = 0, gap_ns = 0;
    bit         first_rise = 1'b0;

    function automatic logic [7:0] resp(input int j);
        return 8'(j * 37) ^ 8'hC3;
    endfunction

    always @(negedge spi_cs_n) begin
        s_bits = 0; cap_n = 0; s_tx = resp(0); spi_miso = s_tx[7];
        t_cs_fall = $time; first_rise = 1'b1; gap_ns = $time - t_cs_rise;
    end
    always @(posedge spi_cs_n) t_cs_rise = $time;
    always @(posedge spi_sck) if (!spi_cs_n) begin
        s_rx = {s_rx[6:0], spi_mosi}; s_bits++;
        if (s_bits % 8 == 0) begin cap[s_bits/8 - 1] = s_rx; cap_n = s_bits / 8; end
        if (first_rise) lead_ns = $time - t_cs_fall;
        else            per_ns = $time - t_prev;
        t_prev = $time; first_rise = 1'b0;
    end
    always @(negedge spi_sck) if (!spi_cs_n) begin
        if (s_bits % 8 == 0) s_tx = resp(s_bits / 8);
        else                 s_tx = {s_tx[6:0], 1'b0};
        spi_miso = s_tx[7];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] d;
        int guard;
        d = 8'h01; guard = 0;
        while (d[0] && guard < 5000) begin rd(OFS_CTRL, d); guard++; end
        chk(!d[0], "R5 busy clears", int'(d[0]), 0);
    endtask

    task automatic check_ring(input string tag);
        logic [7:0] d;
        wr(OFS_CTRL, 8'h10);
        for (int k = 0; k < 8; k++) begin
            rd(OFS_DATA, d);
            chk(d == m[k], tag, int'(d), int'(m[k]));
        end
    endtask

    task automatic check_wire(input int total);
        logic [7:0] e;
        for (int j = 1; j <= total; j++) begin
            e = m[(j-1) % 8];
            chk(cap[j] == e, "R7 entry sent from pointer", int'(cap[j]), int'(e));
            m[(j-1) % 8] = resp(j);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, op;
        int wc, rc, n, prev_n;
        bit have_prev;
        have_prev = 1'b0; prev_n = 2;
        for (int k = 0; k < 8; k++) m[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(spi_cs_n == 1'b1, "R1 cs_n high", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1 sck low", int'(spi_sck), 0);
        rd(OFS_CTRL, d);   chk(d == 8'h00, "R1 busy", int'(d), 0);
        rd(OFS_OPCODE, d); chk(d == 8'h00, "R1 opcode", int'(d), 0);
        rd(OFS_COUNT, d);  chk(d == 8'h00, "R1 counts", int'(d), 0);
        rd(OFS_CFG, d);    chk(d == 8'h10, "R1 cfg/pointer", int'(d), 8'h10);

        // R2 count readback
        wr(OFS_COUNT, 8'h85); rd(OFS_COUNT, d);
        chk(d == 8'h85, "R2 counts readback", int'(d), 8'h85);

        // R3 data port write, wrap and readback; R4 pointer reset
        wr(OFS_CTRL, 8'h10);
        for (int k = 0; k < 10; k++) begin
            wr(OFS_DATA, 8'(8'h70 + k)); m[k % 8] = 8'(8'h70 + k);
        end
        rd(OFS_CFG, d); chk(d[2:0] == 3'd2, "R3 pointer after 10 writes", int'(d[2:0]), 2);
        wr(OFS_CTRL, 8'h10);
        rd(OFS_CFG, d); chk(d[2:0] == 3'd0, "R4 pointer reset", int'(d[2:0]), 0);
        for (int k = 0; k < 8; k++) begin
            rd(OFS_DATA, d); chk(d == m[k], "R3 data port read", int'(d), int'(m[k]));
        end
        rd(OFS_CFG, d); chk(d[2:0] == 3'd0, "R3 pointer wraps", int'(d[2:0]), 0);

        // table walk: R5 R6 R7 R8 R10
        for (int v = 0; v < 6; v++) begin
            op = VEC[v][23:16]; wc = int'(VEC[v][15:12]); rc = int'(VEC[v][11:8]);
            n  = int'(sck_period(VEC[v][1:0]));
            wr(OFS_CFG, {2'b00, VEC[v][1:0], 4'h0});
            wr(OFS_OPCODE, op);
            wr(OFS_COUNT, {VEC[v][11:8], VEC[v][15:12]});
            wr(OFS_CTRL, 8'h10);
            for (int k = 0; k < wc; k++) begin
                wr(OFS_DATA, 8'(8'h30 + v*16 + k)); m[k] = 8'(8'h30 + v*16 + k);
            end
            wr(OFS_CTRL, 8'h01);
            rd(OFS_CTRL, d); chk(d[0] == 1'b1, "R5 busy set", int'(d[0]), 1);
            wait_idle();
            chk(cap_n == 1 + wc + rc, "R6 byte count", cap_n, 1 + wc + rc);
            chk(cap[0] == op, "R6 opcode first MSB first", int'(cap[0]), int'(op));
            check_wire(wc + rc);
            chk(per_ns == time'(n*4), "R8 sck period", int'(per_ns), n*4);
            chk(lead_ns*2 >= time'(n*4), "R10 cs lead", int'(lead_ns), n*2);
            if (have_prev) chk(gap_ns >= time'(prev_n*4), "R10 cs gap", int'(gap_ns), prev_n*4);
            rd(OFS_CFG, d);
            chk(int'(d[2:0]) == (wc + rc) % 8, "R7 end pointer", int'(d[2:0]), (wc + rc) % 8);
            check_ring("R7 ring contents");
            prev_n = n; have_prev = 1'b1;
        end

        // R9 writes and data reads ignored while busy
        wr(OFS_CFG, 8'h30);
        wr(OFS_OPCODE, 8'h3B);
        wr(OFS_COUNT, 8'h88);
        wr(OFS_CTRL, 8'h10);
        for (int k = 0; k < 8; k++) begin
            wr(OFS_DATA, 8'(8'hB0 + k)); m[k] = 8'(8'hB0 + k);
        end
        wr(OFS_CTRL, 8'h01);
        wr(OFS_OPCODE, 8'hFF);
        wr(OFS_COUNT, 8'h11);
        wr(OFS_DATA, 8'hEE);
        wr(OFS_CTRL, 8'h10);
        rd(OFS_DATA, d);
        rd(OFS_CTRL, d); chk(d[0] == 1'b1, "R5 still busy", int'(d[0]), 1);
        wait_idle();
        rd(OFS_OPCODE, d); chk(d == 8'h3B, "R9 opcode kept", int'(d), 8'h3B);
        rd(OFS_COUNT, d);  chk(d == 8'h88, "R9 counts kept", int'(d), 8'h88);
        rd(OFS_CFG, d);    chk(d[2:0] == 3'd0, "R9 end pointer", int'(d[2:0]), 0);
        chk(cap_n == 17, "R9 byte count", cap_n, 17);
        chk(cap[0] == 8'h3B, "R9 opcode on wire", int'(cap[0]), 8'h3B);
        check_wire(16);
        check_ring("R9 ring contents");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule